// File: doc/BRIEF.md
# Strobe-Driven FIFO Controller with Rewind and Chained Ownership

This block is a first-in first-out buffer for 9-bit words. Writers and readers drive active-low strobes. A system clock samples the strobes, and each high-to-low transition of a sampled strobe commits exactly one operation. A write pointer and a read pointer index an internal two-port array. Flags derived from the pointers report empty, full and half-full. While the read strobe is low, an output-enable signal marks the data outputs as driven. At all other times the outputs are treated as released (high impedance).

In solo operation the block can rewind. Holding the rewind input low while both strobes are high sends the read pointer back to the first word written since reset. That word and the ones after it can then be read again. In chained operation several copies form a ring. Write ownership and read ownership travel around the ring as tokens. The shared half-full/token pin then carries a one-clock pulse each time the device fills its last free location or empties its last stored word. The next device takes that pulse on its token input. A first-load input, sampled while reset is held, decides which device starts with both tokens.

Top module: `fifo_chain_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pointers clear, `empty` reads 1, `full` reads 0, `hf_xo` reads 0 and `dout` reads 0.
- R2: Words leave in the order they entered. A strobe held low for many cycles still commits only one operation, at the first clock edge that sees it low after a high sample.
- R3: A write strobe while `full` is 1 changes neither the stored data nor the occupancy.
- R4: A read strobe while `empty` is 1 moves no pointer, and `dout` keeps its previous value.
- R5: `full` is 1 exactly when DEPTH words are held. `empty` is 1 exactly when none are held.
- R6: With `chain_mode` = 0, `hf_xo` is 1 when occupancy is at least DEPTH/2 and 0 below that.
- R7: `dout_oe` is 1 only while `rd_n` is 0.
- R8: With `chain_mode` = 0, `rt_n` low at an edge where `wr_n` and `rd_n` are both high rewinds reading. The next read returns the oldest word written since reset, provided no more than DEPTH words were written in that time.
- R9: With `chain_mode` = 1, `rt_n` has no effect on the read position.
- R10: With `chain_mode` = 1, writes commit only while the device holds the write token and reads commit only while it holds the read token. At reset, both tokens are set to the value of `first_load`.
- R11: With `chain_mode` = 1, `hf_xo` pulses high for one clock after the write that fills the last free location or the read that takes the last stored word. The matching token is dropped at that same edge, and `hf_xo` does not show half-full.
- R12: A one-clock high on `xi` grants the write token if the device holds no write token and is empty. Otherwise it grants the read token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| chain_mode | input | 1 | 0 = solo/width use, 1 = ring of chained devices |
| first_load | input | 1 | Sampled at reset: device starts with both tokens |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low rewind request (solo only) |
| xi | input | 1 | Token pulse from the previous device in the ring |
| din | input | 9 | Write data |
| dout | output | 9 | Read data, valid while `dout_oe` is 1 |
| dout_oe | output | 1 | Output drive enable |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| hf_xo | output | 1 | Half-full (solo) or token-out pulse (chained) |

## Verification
The bench holds a write strobe low for several cycles. A design that acted on the level instead of the edge would store repeated words, and they would show up as extra data on later reads. It fills the buffer exactly, writes once more and drains it. Off-by-one errors in the full, empty or half-full compares, or a write that overwrites when full, appear as a wrong flag or a corrupted word. It rewinds after a partial read, in both modes. A rewind that ignores the mode, or rewinds to the wrong place, returns an unexpected word. In chained operation it strobes without holding a token and sends token pulses in both the empty and non-empty states. Misgranting a token, or a missing or stretched token-out pulse, is visible on the flags and on `hf_xo`.

// File: rtl/fifo_chain_pkg.sv
// Package: shared configuration type and helpers for the chained FIFO.
// Assumes DEPTH is a power of two and at least 4.
package fifo_chain_pkg;
    typedef enum logic {
        CFG_SOLO  = 1'b0,
        CFG_CHAIN = 1'b1
    } cfg_e;

    // Pointer width with one extra wrap bit.
    function automatic int ptr_width(input int depth);
        return $clog2(depth) + 1;
    endfunction
endpackage

// File: rtl/strobe_fall_det.sv
// Module: strobe_fall_det
// Samples N active-low strobes on the clock and flags the first clocked
// low sample after a high one. Assumes strobes are already synchronous to clk.
module strobe_fall_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] fire
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_det
        // Remember the last sample of this strobe; idle is high.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b1;
            else        prev_q[g] <= strobe_n[g];
        end
        assign fire[g] = prev_q[g] & ~strobe_n[g];

        // R2: a strobe held low may fire only once
        p_single_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
            fire[g] |=> !fire[g]);
    end
endmodule

// File: rtl/fifo_ptr_ctrl.sv
// Module: fifo_ptr_ctrl
// Keeps write/read pointers with a wrap bit, derives occupancy and flags,
// and performs the rewind. Assumes callers gate wr_do/rd_do against flags.
module fifo_ptr_ctrl #(
    parameter int DEPTH = 32,
    localparam int PTR_W  = fifo_chain_pkg::ptr_width(DEPTH),
    localparam int ADDR_W = PTR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic              rd_fire,
    input  logic              wr_do,
    input  logic              rd_do,
    input  logic              rewind,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PTR_W-1:0]  count,
    output logic              empty,
    output logic              full,
    output logic              half
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] HALF_P  = PTR_W'(DEPTH / 2);

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] rewind_to;

    // Oldest word still stored since reset.
    always_comb begin
        if (wr_ptr > DEPTH_P) rewind_to = wr_ptr - DEPTH_P;
        else                  rewind_to = '0;
    end

    // Advance the write pointer on each committed write.
    always_ff @(posedge clk) begin
        if (!rst_n)     wr_ptr <= '0;
        else if (wr_do) wr_ptr <= wr_ptr + 1'b1;
    end

    // Advance or rewind the read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_ptr <= '0;
        else if (rewind) rd_ptr <= rewind_to;
        else if (rd_do)  rd_ptr <= rd_ptr + 1'b1;
    end

    assign count   = wr_ptr - rd_ptr;
    assign empty   = (count == '0);
    assign full    = (count == DEPTH_P);
    assign half    = (count >= HALF_P);
    assign wr_addr = wr_ptr[ADDR_W-1:0];
    assign rd_addr = rd_ptr[ADDR_W-1:0];

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_P);
    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_fire |=> $stable(wr_ptr));
    p_empty_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_fire && !rewind |=> $stable(rd_ptr));
    p_one_per_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(wr_ptr));
    p_flags_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
endmodule

// File: rtl/fifo_store.sv
// Module: fifo_store
// Two-port word array with a registered read port that updates only on a
// committed read. Assumes write and read never target the same unread slot.
module fifo_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 9,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_do,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_do,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word.
    always_ff @(posedge clk) begin
        if (wr_do) mem[wr_addr] <= wr_data;
    end

    // Capture the outgoing word; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_do) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/chain_token_unit.sv
// Module: chain_token_unit
// Holds write/read ownership for a ring of chained devices, emits a
// one-clock token-out pulse on the last write or last read, and takes
// token pulses in. Assumes the read token always trails the write token.
module chain_token_unit #(
    parameter int DEPTH = 32,
    localparam int PTR_W = fifo_chain_pkg::ptr_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chain,
    input  logic             first_load,
    input  logic             xi,
    input  logic             wr_do,
    input  logic             rd_do,
    input  logic [PTR_W-1:0] count,
    output logic             wr_tok,
    output logic             rd_tok,
    output logic             xo
);
    logic last_wr, last_rd, take_wr, take_rd;

    assign last_wr = chain & wr_do & (count == PTR_W'(DEPTH - 1));
    assign last_rd = chain & rd_do & (count == PTR_W'(1));
    assign take_wr = xi & ~wr_tok & (count == '0);
    assign take_rd = xi & ~take_wr;

    // Write ownership: seeded at reset, dropped on last write, granted by xi.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_tok <= first_load;
        else if (last_wr) wr_tok <= 1'b0;
        else if (take_wr) wr_tok <= 1'b1;
    end

    // Read ownership: seeded at reset, dropped on last read, granted by xi.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_tok <= first_load;
        else if (last_rd) rd_tok <= 1'b0;
        else if (take_rd) rd_tok <= 1'b1;
    end

    // Token-out pulse, one clock long.
    always_ff @(posedge clk) begin
        if (!rst_n) xo <= 1'b0;
        else        xo <= last_wr | last_rd;
    end

    p_xo_one_clock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xo |=> !xo);
    p_no_wr_without_tok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chain && !wr_tok |-> !wr_do);
    p_no_rd_without_tok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chain && !rd_tok |-> !rd_do);
    p_last_wr_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        last_wr |=> !wr_tok && xo);
endmodule

// File: rtl/fifo_chain_ctrl.sv
// Module: fifo_chain_ctrl (top)
// Strobe-driven FIFO controller: edge-detects the strobes, gates commits
// by flags, mode and tokens, applies rewind in solo mode, and muxes the
// half-full flag or token pulse onto hf_xo. Assumes clk oversamples strobes.
module fifo_chain_ctrl #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 9,
    localparam int PTR_W  = fifo_chain_pkg::ptr_width(DEPTH),
    localparam int ADDR_W = PTR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_mode,
    input  logic              first_load,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rt_n,
    input  logic              xi,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              empty,
    output logic              full,
    output logic              hf_xo
);
    import fifo_chain_pkg::*;

    cfg_e              cfg;
    logic [1:0]        fire;
    logic              wr_do, rd_do, rewind;
    logic              wr_tok, rd_tok, xo, half;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [PTR_W-1:0]  count;

    assign cfg = cfg_e'(chain_mode);

    strobe_fall_det #(.N(2)) i_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({rd_n, wr_n}),
        .fire     (fire)
    );

    // Commit gating: edge, flag and (in a ring) ownership.
    always_comb begin
        wr_do  = fire[0] & ~full  & ((cfg == CFG_SOLO) | wr_tok);
        rd_do  = fire[1] & ~empty & ((cfg == CFG_SOLO) | rd_tok);
        rewind = (cfg == CFG_SOLO) & ~rt_n & wr_n & rd_n;
    end

    fifo_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (fire[0]),
        .rd_fire (fire[1]),
        .wr_do   (wr_do),
        .rd_do   (rd_do),
        .rewind  (rewind),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .count   (count),
        .empty   (empty),
        .full    (full),
        .half    (half)
    );

    fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_do   (wr_do),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_do   (rd_do),
        .rd_addr (rd_addr),
        .rd_data (dout)
    );

    chain_token_unit #(.DEPTH(DEPTH)) i_tok (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain      (cfg == CFG_CHAIN),
        .first_load (first_load),
        .xi         (xi),
        .wr_do      (wr_do),
        .rd_do      (rd_do),
        .count      (count),
        .wr_tok     (wr_tok),
        .rd_tok     (rd_tok),
        .xo         (xo)
    );

    // Output drive and shared flag/token pin.
    always_comb begin
        dout_oe = ~rd_n;
        hf_xo   = (cfg == CFG_CHAIN) ? xo : half;
    end

    p_chain_hides_half_r11: assert property (@(posedge clk) disable iff (!rst_n)
        chain_mode && !xo |-> !hf_xo);
    p_oe_follows_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> !dout_oe);
endmodule

// File: tb/test_fifo_chain_ctrl.sv
// Directed bench for fifo_chain_ctrl: one task per scenario.
module test_fifo_chain_ctrl;
    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chain_mode = 1'b0, first_load = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1, xi = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_oe, empty, full, hf_xo;

    int n_chk = 0, n_bad = 0;
    logic       xo_mid;
    logic [8:0] rd_val;
    logic       oe_mid;

    always #(CLK_P/2) clk = ~clk;

    fifo_chain_ctrl #(.DEPTH(DEPTH), .DATA_W(9)) i_fifo_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .chain_mode(chain_mode), .first_load(first_load),
        .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n), .xi(xi), .din(din),
        .dout(dout), .dout_oe(dout_oe), .empty(empty), .full(full), .hf_xo(hf_xo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic chain, input logic fl);
        @(negedge clk);
        rst_n = 1'b0; chain_mode = chain; first_load = fl;
        wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; xi = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One write strobe; hold_cyc extra low cycles; xo_mid sampled after commit.
    task automatic wr_word(input logic [8:0] d, input int hold_cyc);
        din = d; wr_n = 1'b0;
        @(negedge clk);
        xo_mid = hf_xo;
        repeat (hold_cyc) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_word();
        rd_n = 1'b0;
        @(negedge clk);
        rd_val = dout; oe_mid = dout_oe; xo_mid = hf_xo;
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_xi();
        xi = 1'b1;
        @(negedge clk);
        xi = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rt();
        rt_n = 1'b0;
        repeat (2) @(negedge clk);
        rt_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0);
        chk(empty == 1'b1, "R1 empty", empty, 1);
        chk(full == 1'b0,  "R1 full", full, 0);
        chk(hf_xo == 1'b0, "R1 hf_xo", hf_xo, 0);
        chk(dout == 9'd0,  "R1 dout", dout, 0);
        chk(dout_oe == 1'b0, "R7 idle oe", dout_oe, 0);
    endtask

    task automatic t_order();
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) wr_word(9'(37 * i + 5), 0);
        wr_word(9'h1A5, 4);                      // held low: one word only
        for (int i = 0; i < 5; i++) begin
            rd_word();
            chk(rd_val == 9'(37 * i + 5), "R2 order", rd_val, 37 * i + 5);
            chk(oe_mid == 1'b1, "R7 oe during read", oe_mid, 1);
        end
        rd_word();
        chk(rd_val == 9'h1A5, "R2 held strobe word", rd_val, 'h1A5);
        chk(empty == 1'b1, "R2 held strobe single write", empty, 1);
        rd_word();
        chk(rd_val == 9'h1A5, "R4 empty read holds dout", rd_val, 'h1A5);
        chk(empty == 1'b1, "R4 still empty", empty, 1);
    endtask

    task automatic t_fill();
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(9'(i + 100), 0);
            if (i == DEPTH/2 - 2) chk(hf_xo == 1'b0, "R6 below half", hf_xo, 0);
            if (i == DEPTH/2 - 1) chk(hf_xo == 1'b1, "R6 at half", hf_xo, 1);
            if (i == DEPTH - 2)   chk(full == 1'b0, "R5 not yet full", full, 0);
        end
        chk(full == 1'b1, "R5 full", full, 1);
        wr_word(9'h0FF, 0);
        chk(full == 1'b1, "R3 still full", full, 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd_word();
            chk(rd_val == 9'(i + 100), "R3 no overwrite", rd_val, i + 100);
            if (i == DEPTH/2) chk(hf_xo == 1'b0, "R6 drops below half", hf_xo, 0);
        end
        chk(empty == 1'b1, "R5 empty after drain", empty, 1);
        rd_word();
        chk(rd_val == 9'(DEPTH - 1 + 100), "R4 empty read", rd_val, DEPTH - 1 + 100);
    endtask

    task automatic t_rewind();
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) wr_word(9'(i + 200), 0);
        rd_word(); rd_word();
        pulse_rt();
        chk(empty == 1'b0, "R8 rewind refills", empty, 0);
        for (int i = 0; i < 3; i++) begin
            rd_word();
            chk(rd_val == 9'(i + 200), "R8 replay", rd_val, i + 200);
        end
        chk(empty == 1'b1, "R8 empty after replay", empty, 1);
    endtask

    task automatic t_chain();
        do_reset(1'b1, 1'b0);
        wr_word(9'h0AA, 0);
        chk(empty == 1'b1, "R10 write without token", empty, 1);
        pulse_xi();                                   // empty, no write token
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(9'(i + 300), 0);
            if (i == DEPTH/2) chk(xo_mid == 1'b0, "R11 no half on pin", xo_mid, 0);
            if (i == DEPTH - 1) chk(xo_mid == 1'b1, "R11 pulse on last write", xo_mid, 1);
        end
        chk(hf_xo == 1'b0, "R11 pulse one clock", hf_xo, 0);
        chk(full == 1'b1, "R12 write token granted", full, 1);
        rd_word();
        chk(full == 1'b1, "R10 read without token", full, 1);
        pulse_xi();                                   // not empty: read token
        for (int i = 0; i < 3; i++) begin
            rd_word();
            chk(rd_val == 9'(i + 300), "R12 read token granted", rd_val, i + 300);
        end
        pulse_rt();
        rd_word();
        chk(rd_val == 9'(303), "R9 rewind ignored", rd_val, 303);
        for (int i = 4; i < DEPTH; i++) begin
            rd_word();
            if (i == DEPTH - 1) begin
                chk(xo_mid == 1'b1, "R11 pulse on last read", xo_mid, 1);
                chk(rd_val == 9'(i + 300), "R2 chained order", rd_val, i + 300);
            end
        end
        chk(empty == 1'b1, "R11 drained", empty, 1);
        wr_word(9'h055, 0);
        chk(empty == 1'b1, "R10 write token was passed", empty, 1);
    endtask

    task automatic t_first_load();
        do_reset(1'b1, 1'b1);
        wr_word(9'h077, 0);
        chk(empty == 1'b0, "R10 first_load owns write", empty, 0);
        rd_word();
        chk(rd_val == 9'h077, "R10 first_load owns read", rd_val, 'h077);
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_fill();
        t_rewind();
        t_chain();
        t_first_load();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule